// File: doc/BRIEF.md
# Accumulator ALU execute stage with status flags

This block is the execute stage for the register and literal operations of an 8-bit accumulator machine with 14-bit instruction words. The decoder hands it one operation per cycle: an operation code, the accumulator, the register operand, an 8-bit literal, a 3-bit bit index, the destination bit `d` and the current carry. One clock later the block returns the result and tells the rest of the core what to do with it. It reports which of the accumulator or the register is written. It gives the new carry, half-carry and zero values together with a mask that says which of them the status register takes. It also raises a skip request for the test-and-skip and count-and-skip forms.

The flags follow the target machine's conventions. Subtraction computes register minus accumulator, and its carry and half-carry read as "no borrow". Rotates move through the carry. The bit tests and count-and-skip forms request a skip and leave the flags alone. The status register is not stored here. Its reserved upper bits (7:5) never appear in the mask, and the surrounding core keeps any flag whose mask bit is clear.

Top module: `alu8_exec`

## Requirements
- R1: `op_i` codes are 0 no-op, 1 add, 2 subtract, 3/4/5 AND/OR/XOR with register, 6/7/8 AND/OR/XOR with literal, 9 move literal, 10 complement, 11 move register, 12 increment, 13 decrement, 14 increment-skip, 15 decrement-skip, 16 rotate left, 17 rotate right, 18 nibble swap, 19 clear accumulator, 20 clear register, 21 move accumulator to register, 22 bit clear, 23 bit set, 24 test-skip-if-clear, 25 test-skip-if-set; codes 26 to 31 act as no-op. Codes 1 to 5, 10 to 18 write the accumulator when `d_i`=0 and the register when `d_i`=1; 6 to 9 and 19 write the accumulator; 20 to 23 write the register; no-op and bit tests write nothing and return a result of 0.
- R2: Add gives register plus accumulator. C is the carry out of bit 7, DC is the carry out of bit 3, and C, DC and Z are all updated.
- R3: Subtract gives register minus accumulator. C=1 means no borrow from bit 7, DC=1 means no borrow from bit 3, and C, DC and Z are updated.
- R4: The six logic operations (register and literal forms of AND, OR, XOR) update Z only.
- R5: Rotate left returns `{r[6:0], carry_i}` with new C = r[7]. Rotate right returns `{carry_i, r[7:1]}` with new C = r[0]. Only C is updated.
- R6: Nibble swap, move literal and move accumulator to register update no flag.
- R7: Increment, decrement, complement, move register, clear accumulator and clear register update Z only.
- R8: Increment-skip and decrement-skip update no flag and request a skip exactly when the 8-bit result is 00h.
- R9: Test-skip-if-clear requests a skip when bit `bit_i` of the register is 0. Test-skip-if-set requests a skip when that bit is 1. Neither updates a flag.
- R10: Bit clear and bit set return the register with only bit `bit_i` forced to 0 or 1, and update no flag.
- R11: Z is 1 exactly when the 8-bit result is 00h, whenever Z is updated. A flag that is not updated is output as 0 for DC and Z, and as `carry_i` for C.
- R12: Outputs are registered with one cycle of latency and `valid_o` follows `valid_i`. After reset, and in a cycle following `valid_i`=0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 5 | Operation code (see R1) |
| acc_i | input | 8 | Accumulator value |
| reg_i | input | 8 | Register operand value |
| imm_i | input | 8 | Literal operand |
| bit_i | input | 3 | Bit index for bit set, clear and test |
| d_i | input | 1 | Destination bit: 0 accumulator, 1 register |
| carry_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Result valid |
| result_o | output | 8 | Operation result |
| wr_acc_o | output | 1 | Write result to the accumulator |
| wr_reg_o | output | 1 | Write result back to the register |
| c_o | output | 1 | New carry value |
| dc_o | output | 1 | New half-carry value |
| z_o | output | 1 | New zero value |
| upd_c_o | output | 1 | Status takes `c_o` |
| upd_dc_o | output | 1 | Status takes `dc_o` |
| upd_z_o | output | 1 | Status takes `z_o` |
| skip_o | output | 1 | Skip the next instruction |

## Verification
The assertions check, on every cycle, the following: the zero flag agrees with the registered result, carry passes through when it is not updated, the two write enables never fire together, and idle cycles produce no write, mask or skip. They also check the add, subtract and rotate carry rules against the operands captured one cycle earlier. The bench covers the whole operation table across random operands and the corner values. These include a sum that wraps to zero, a subtract of equal operands, a borrow from the low nibble alone, count-and-skip reaching zero from both sides, bit tests at the end positions, and the reserved codes. No single-cycle property captures all of this.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_NOP   = 5'd0,
    OP_ADD   = 5'd1,
    OP_SUB   = 5'd2,
    OP_AND_R = 5'd3,
    OP_OR_R  = 5'd4,
    OP_XOR_R = 5'd5,
    OP_AND_I = 5'd6,
    OP_OR_I  = 5'd7,
    OP_XOR_I = 5'd8,
    OP_MOV_I = 5'd9,
    OP_COM   = 5'd10,
    OP_MOV_R = 5'd11,
    OP_INC   = 5'd12,
    OP_DEC   = 5'd13,
    OP_INCSZ = 5'd14,
    OP_DECSZ = 5'd15,
    OP_RL    = 5'd16,
    OP_RR    = 5'd17,
    OP_SWAP  = 5'd18,
    OP_CLR_A = 5'd19,
    OP_CLR_R = 5'd20,
    OP_MOV_AR= 5'd21,
    OP_BCLR  = 5'd22,
    OP_BSET  = 5'd23,
    OP_BTSC  = 5'd24,
    OP_BTSS  = 5'd25
  } alu_op_e;

  typedef enum logic [1:0] {DST_NONE, DST_ACC, DST_REG, DST_D} dst_e;
  typedef enum logic [1:0] {SK_NONE, SK_ZERO, SK_BCLR, SK_BSET} skip_e;
  typedef enum logic [1:0] {B_ACC, B_NACC, B_ZERO, B_ONES} addb_e;

  typedef struct packed {
    dst_e  dst;
    logic  upd_c;
    logic  upd_dc;
    logic  upd_z;
    skip_e skip;
    addb_e add_b;
    logic  add_cin;
    logic  rot_c;
  } dec_t;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             hcout_o
);
  localparam int HALF = WIDTH / 2;
  localparam int UPPER = WIDTH - HALF;

  logic [HALF:0]  lo;
  logic [UPPER:0] hi;

  // split at the nibble boundary so the half carry is a real adder output
  always_comb begin
    lo = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]} + {{HALF{1'b0}}, cin_i};
    hi = {1'b0, a_i[WIDTH-1:HALF]} + {1'b0, b_i[WIDTH-1:HALF]} + {{UPPER{1'b0}}, lo[HALF]};
  end

  assign sum_o   = {hi[UPPER-1:0], lo[HALF-1:0]};
  assign cout_o  = hi[UPPER];
  assign hcout_o = lo[HALF];
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops #(
  parameter int WIDTH = 8,
  parameter int SELW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [SELW-1:0]  sel_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] rl_o,
  output logic [WIDTH-1:0] rr_o,
  output logic [WIDTH-1:0] swap_o,
  output logic [WIDTH-1:0] set_o,
  output logic [WIDTH-1:0] clr_o,
  output logic             bit_o
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] mask;

  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign mask[i] = (sel_i == SELW'(i));
  end

  assign rl_o   = {val_i[WIDTH-2:0], cin_i};
  assign rr_o   = {cin_i, val_i[WIDTH-1:1]};
  assign swap_o = {val_i[HALF-1:0], val_i[WIDTH-1:HALF]};
  assign set_o  = val_i | mask;
  assign clr_o  = val_i & ~mask;
  assign bit_o  = |(val_i & mask);
endmodule

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [4:0] op_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o = '{dst: DST_NONE, upd_c: 1'b0, upd_dc: 1'b0, upd_z: 1'b0,
              skip: SK_NONE, add_b: B_ACC, add_cin: 1'b0, rot_c: 1'b0};
    case (op_i)
      OP_ADD:   begin dec_o.dst = DST_D; dec_o.upd_c = 1'b1; dec_o.upd_dc = 1'b1; dec_o.upd_z = 1'b1; end
      OP_SUB:   begin
        dec_o.dst = DST_D; dec_o.upd_c = 1'b1; dec_o.upd_dc = 1'b1; dec_o.upd_z = 1'b1;
        dec_o.add_b = B_NACC; dec_o.add_cin = 1'b1;
      end
      OP_AND_R, OP_OR_R, OP_XOR_R, OP_COM, OP_MOV_R:
                begin dec_o.dst = DST_D; dec_o.upd_z = 1'b1; end
      OP_AND_I, OP_OR_I, OP_XOR_I, OP_CLR_A:
                begin dec_o.dst = DST_ACC; dec_o.upd_z = 1'b1; end
      OP_MOV_I: dec_o.dst = DST_ACC;
      OP_INC:   begin dec_o.dst = DST_D; dec_o.upd_z = 1'b1; dec_o.add_b = B_ZERO; dec_o.add_cin = 1'b1; end
      OP_DEC:   begin dec_o.dst = DST_D; dec_o.upd_z = 1'b1; dec_o.add_b = B_ONES; end
      OP_INCSZ: begin dec_o.dst = DST_D; dec_o.skip = SK_ZERO; dec_o.add_b = B_ZERO; dec_o.add_cin = 1'b1; end
      OP_DECSZ: begin dec_o.dst = DST_D; dec_o.skip = SK_ZERO; dec_o.add_b = B_ONES; end
      OP_RL, OP_RR:
                begin dec_o.dst = DST_D; dec_o.upd_c = 1'b1; dec_o.rot_c = 1'b1; end
      OP_SWAP:  dec_o.dst = DST_D;
      OP_CLR_R: begin dec_o.dst = DST_REG; dec_o.upd_z = 1'b1; end
      OP_MOV_AR, OP_BCLR, OP_BSET:
                dec_o.dst = DST_REG;
      OP_BTSC:  dec_o.skip = SK_BCLR;
      OP_BTSS:  dec_o.skip = SK_BSET;
      default:  ;
    endcase
  end
endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SELW  = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [4:0]       op_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] reg_i,
  input  logic [WIDTH-1:0] imm_i,
  input  logic [SELW-1:0]  bit_i,
  input  logic             d_i,
  input  logic             carry_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_acc_o,
  output logic             wr_reg_o,
  output logic             c_o,
  output logic             dc_o,
  output logic             z_o,
  output logic             upd_c_o,
  output logic             upd_dc_o,
  output logic             upd_z_o,
  output logic             skip_o
);
  dec_t dec;
  logic [WIDTH-1:0] add_b, sum, rl_v, rr_v, swap_v, set_v, clr_v, res;
  logic cout, hcout, bit_v, res_zero;
  logic c_n, dc_n, z_n, skip_n, wr_acc_n, wr_reg_n;

  alu8_decode u_dec (.op_i(op_i), .dec_o(dec));

  always_comb begin
    case (dec.add_b)
      B_ACC:   add_b = acc_i;
      B_NACC:  add_b = ~acc_i;
      B_ZERO:  add_b = '0;
      default: add_b = '1;
    endcase
  end

  alu8_adder #(.WIDTH(WIDTH)) u_add (
    .a_i(reg_i), .b_i(add_b), .cin_i(dec.add_cin),
    .sum_o(sum), .cout_o(cout), .hcout_o(hcout)
  );

  alu8_bitops #(.WIDTH(WIDTH), .SELW(SELW)) u_bit (
    .val_i(reg_i), .sel_i(bit_i), .cin_i(carry_i),
    .rl_o(rl_v), .rr_o(rr_v), .swap_o(swap_v),
    .set_o(set_v), .clr_o(clr_v), .bit_o(bit_v)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_INCSZ, OP_DECSZ: res = sum;
      OP_AND_R:  res = reg_i & acc_i;
      OP_OR_R:   res = reg_i | acc_i;
      OP_XOR_R:  res = reg_i ^ acc_i;
      OP_AND_I:  res = acc_i & imm_i;
      OP_OR_I:   res = acc_i | imm_i;
      OP_XOR_I:  res = acc_i ^ imm_i;
      OP_MOV_I:  res = imm_i;
      OP_COM:    res = ~reg_i;
      OP_MOV_R:  res = reg_i;
      OP_RL:     res = rl_v;
      OP_RR:     res = rr_v;
      OP_SWAP:   res = swap_v;
      OP_MOV_AR: res = acc_i;
      OP_BCLR:   res = clr_v;
      OP_BSET:   res = set_v;
      default:   res = '0;
    endcase
  end

  assign res_zero = (res == '0);

  always_comb begin
    if (!dec.upd_c)       c_n = carry_i;
    else if (!dec.rot_c)  c_n = cout;
    else if (op_i == OP_RL) c_n = reg_i[WIDTH-1];
    else                  c_n = reg_i[0];
    dc_n = dec.upd_dc & hcout;
    z_n  = dec.upd_z & res_zero;
    case (dec.skip)
      SK_ZERO: skip_n = res_zero;
      SK_BCLR: skip_n = ~bit_v;
      SK_BSET: skip_n = bit_v;
      default: skip_n = 1'b0;
    endcase
    wr_acc_n = (dec.dst == DST_ACC) || (dec.dst == DST_D && !d_i);
    wr_reg_n = (dec.dst == DST_REG) || (dec.dst == DST_D && d_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0; result_o <= '0;
      wr_acc_o <= 1'b0; wr_reg_o <= 1'b0;
      c_o      <= 1'b0; dc_o     <= 1'b0; z_o      <= 1'b0;
      upd_c_o  <= 1'b0; upd_dc_o <= 1'b0; upd_z_o  <= 1'b0;
      skip_o   <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      result_o <= valid_i ? res : '0;
      wr_acc_o <= valid_i & wr_acc_n;
      wr_reg_o <= valid_i & wr_reg_n;
      c_o      <= valid_i & c_n;
      dc_o     <= valid_i & dc_n;
      z_o      <= valid_i & z_n;
      upd_c_o  <= valid_i & dec.upd_c;
      upd_dc_o <= valid_i & dec.upd_dc;
      upd_z_o  <= valid_i & dec.upd_z;
      skip_o   <= valid_i & skip_n;
    end
  end

  // ---------------- assertions ----------------
  p_single_dest_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_acc_o && wr_reg_o));

  p_add_carry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_ADD) |=> upd_c_o && upd_dc_o && upd_z_o &&
      (c_o == (({1'b0, $past(reg_i)} + {1'b0, $past(acc_i)}) > {1'b0, {WIDTH{1'b1}}})));

  p_sub_noborrow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SUB) |=> (c_o == ($past(reg_i) >= $past(acc_i))));

  p_rotl_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_RL) |=> (result_o[0] == $past(carry_i)) &&
      (c_o == $past(reg_i[WIDTH-1])) && !upd_z_o && !upd_dc_o);

  p_zero_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && upd_z_o) |-> (z_o == (result_o == '0)));

  p_carry_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != OP_ADD && op_i != OP_SUB && op_i != OP_RL && op_i != OP_RR)
      |=> !upd_c_o && (c_o == $past(carry_i)));

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !wr_acc_o && !wr_reg_o && !skip_o &&
      !upd_c_o && !upd_dc_o && !upd_z_o);
endmodule

// File: tb/alu8_exec_tb.sv
module alu8_exec_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, d = 1'b0, cin = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] acc = '0, rg = '0, imm = '0;
  logic [2:0] bsel = '0;
  logic valid_o, wr_acc, wr_reg, c, dc, z, uc, udc, uz, skip;
  logic [7:0] res;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu8_exec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .acc_i(acc),
    .reg_i(rg), .imm_i(imm), .bit_i(bsel), .d_i(d), .carry_i(cin),
    .valid_o(valid_o), .result_o(res), .wr_acc_o(wr_acc), .wr_reg_o(wr_reg),
    .c_o(c), .dc_o(dc), .z_o(z), .upd_c_o(uc), .upd_dc_o(udc), .upd_z_o(uz),
    .skip_o(skip)
  );

  // packed order: valid, result, wr_acc, wr_reg, c, dc, z, uc, udc, uz, skip
  function automatic logic [17:0] expect_of(input logic [4:0] o, input logic [7:0] a,
      input logic [7:0] r, input logic [7:0] i, input logic [2:0] b, input logic dd,
      input logic ci);
    logic [7:0] v; logic wa, wrr, fc, fdc, fz, mc, mdc, mz, sk; int dst; // 0 none 1 acc 2 reg 3 d
    v = 8'h00; fc = ci; fdc = 0; mc = 0; mdc = 0; mz = 0; sk = 0; dst = 0;
    case (o)
      5'd1: begin v = r + a; fc = (int'(r) + int'(a)) > 255; fdc = (int'(r[3:0]) + int'(a[3:0])) > 15;
                  mc = 1; mdc = 1; mz = 1; dst = 3; end
      5'd2: begin v = r - a; fc = r >= a; fdc = r[3:0] >= a[3:0]; mc = 1; mdc = 1; mz = 1; dst = 3; end
      5'd3: begin v = r & a; mz = 1; dst = 3; end
      5'd4: begin v = r | a; mz = 1; dst = 3; end
      5'd5: begin v = r ^ a; mz = 1; dst = 3; end
      5'd6: begin v = a & i; mz = 1; dst = 1; end
      5'd7: begin v = a | i; mz = 1; dst = 1; end
      5'd8: begin v = a ^ i; mz = 1; dst = 1; end
      5'd9: begin v = i; dst = 1; end
      5'd10: begin v = ~r; mz = 1; dst = 3; end
      5'd11: begin v = r; mz = 1; dst = 3; end
      5'd12: begin v = r + 8'd1; mz = 1; dst = 3; end
      5'd13: begin v = r - 8'd1; mz = 1; dst = 3; end
      5'd14: begin v = r + 8'd1; sk = (v == 0); dst = 3; end
      5'd15: begin v = r - 8'd1; sk = (v == 0); dst = 3; end
      5'd16: begin v = {r[6:0], ci}; fc = r[7]; mc = 1; dst = 3; end
      5'd17: begin v = {ci, r[7:1]}; fc = r[0]; mc = 1; dst = 3; end
      5'd18: begin v = {r[3:0], r[7:4]}; dst = 3; end
      5'd19: begin v = 8'h00; mz = 1; dst = 1; end
      5'd20: begin v = 8'h00; mz = 1; dst = 2; end
      5'd21: begin v = a; dst = 2; end
      5'd22: begin v = r; v[b] = 1'b0; dst = 2; end
      5'd23: begin v = r; v[b] = 1'b1; dst = 2; end
      5'd24: sk = !r[b];
      5'd25: sk = r[b];
      default: ;
    endcase
    fz = mz && (v == 0);
    if (!mdc) fdc = 0;
    if (!mc) fc = ci;
    wa  = (dst == 1) || (dst == 3 && !dd);
    wrr = (dst == 2) || (dst == 3 && dd);
    return {1'b1, v, wa, wrr, fc, fdc, fz, mc, mdc, mz, sk};
  endfunction

  function automatic string req_of(input logic [4:0] o);
    case (o)
      5'd1: return "R2 R11";
      5'd2: return "R3 R11";
      5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8: return "R4 R11";
      5'd9, 5'd18, 5'd21: return "R6 R1";
      5'd10, 5'd11, 5'd12, 5'd13, 5'd19, 5'd20: return "R7 R11";
      5'd14, 5'd15: return "R8";
      5'd16, 5'd17: return "R5";
      5'd22, 5'd23: return "R10";
      5'd24, 5'd25: return "R9";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [17:0] observed();
    return {valid_o, res, wr_acc, wr_reg, c, dc, z, uc, udc, uz, skip};
  endfunction

  task automatic compare(input logic [17:0] exp, input string tag);
    checks++;
    if (observed() !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h (op=%0d acc=%h reg=%h imm=%h bit=%0d d=%0b c=%0b)",
               tag, observed(), exp, op, acc, rg, imm, bsel, d, cin);
    end
  endtask

  // called at a falling edge; checks one cycle later at the next falling edge
  task automatic run(input logic [4:0] o, input logic [7:0] a, input logic [7:0] r,
      input logic [7:0] i, input logic [2:0] b, input logic dd, input logic ci);
    valid = 1'b1; op = o; acc = a; rg = r; imm = i; bsel = b; d = dd; cin = ci;
    @(posedge clk); @(negedge clk);
    compare(expect_of(o, a, r, i, b, dd, ci), req_of(o));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    compare(18'h0, "R12 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare(18'h0, "R12 after reset");

    // directed corners
    run(5'd1, 8'h01, 8'hFF, 8'h00, 3'd0, 1'b0, 1'b0); // R2 wrap to zero, C=DC=Z=1
    run(5'd1, 8'h08, 8'h08, 8'h00, 3'd0, 1'b1, 1'b1); // R2 half carry only
    run(5'd2, 8'h5A, 8'h5A, 8'h00, 3'd0, 1'b0, 1'b0); // R3 equal: C=1 DC=1 Z=1
    run(5'd2, 8'h01, 8'h10, 8'h00, 3'd0, 1'b1, 1'b0); // R3 low nibble borrow only
    run(5'd2, 8'h01, 8'h00, 8'h00, 3'd0, 1'b0, 1'b1); // R3 full borrow: C=0
    run(5'd14, 8'h00, 8'hFF, 8'h00, 3'd0, 1'b1, 1'b1); // R8 inc to zero skips
    run(5'd15, 8'h00, 8'h01, 8'h00, 3'd0, 1'b0, 1'b0); // R8 dec to zero skips
    run(5'd15, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0); // R8 dec wraps, no skip
    run(5'd16, 8'h00, 8'h80, 8'h00, 3'd0, 1'b1, 1'b0); // R5 rotate left carry out
    run(5'd17, 8'h00, 8'h01, 8'h00, 3'd0, 1'b1, 1'b1); // R5 rotate right through carry
    run(5'd24, 8'h00, 8'h7F, 8'h00, 3'd7, 1'b0, 1'b1); // R9 bit 7 clear -> skip
    run(5'd25, 8'h00, 8'h01, 8'h00, 3'd0, 1'b0, 1'b0); // R9 bit 0 set -> skip
    run(5'd22, 8'h00, 8'hFF, 8'h00, 3'd7, 1'b0, 1'b1); // R10 clear top bit
    run(5'd23, 8'h00, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0); // R10 set bottom bit
    run(5'd6, 8'hF0, 8'h00, 8'h0F, 3'd0, 1'b1, 1'b1);  // R4 literal AND to zero
    run(5'd18, 8'h00, 8'hA5, 8'h00, 3'd0, 1'b0, 1'b1); // R6 swap
    run(5'd20, 8'h33, 8'h77, 8'h00, 3'd0, 1'b0, 1'b1); // R7 clear register
    run(5'd30, 8'h12, 8'h34, 8'h56, 3'd1, 1'b1, 1'b1); // R1 reserved acts as no-op

    // idle cycle with junk operands
    valid = 1'b0; op = 5'd1; acc = 8'hFF; rg = 8'h01; d = 1'b1; cin = 1'b1;
    @(posedge clk); @(negedge clk);
    compare(18'h0, "R12 idle");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      run(5'($urandom % 32), 8'($urandom), 8'($urandom), 8'($urandom),
          3'($urandom), 1'($urandom), 1'($urandom));
      if (k % 97 == 0) begin
        valid = 1'b0; op = 5'($urandom); rg = 8'($urandom);
        @(posedge clk); @(negedge clk);
        compare(18'h0, "R12 idle");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule